// File: doc/BRIEF.md
# Reservation-Tracked Atomic Access Unit

This block sits between one processor port and a small word-organised memory held inside it. The core sends it four kinds of request: a plain read, a plain write, a reserving read, and a conditional write. A reserving read returns the addressed word and marks that word as reserved. A later conditional write to the same word commits only if nothing has written that word in the meantime. The block reports whether the conditional write committed. Software builds atomic read-modify-write loops from the pair, and repeats the loop when the conditional write reports a miss.

A second, receive-only port tells the block the word address of each write made by another agent. That port carries no data and never changes the internal memory. Its only effect is to break a reservation held on the same word. There is a single reservation slot. Addresses are byte addresses, and the two lowest bits are dropped without any alignment check.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset no response is pending, every memory word reads zero, and no reservation is held, so a conditional write issued first fails and changes nothing.
- R2: A plain read (op 00) or a reserving read (op 10) returns the addressed word on `rsp_rdata` with `rsp_sc_pass` low, in the cycle after acceptance.
- R3: A plain write (op 01) stores `req_wdata` into the addressed word and answers one cycle later with `rsp_rdata` zero and `rsp_sc_pass` low.
- R4: A reserving read reserves its word. A conditional write (op 11) to that word with no write to the word in between answers with `rsp_sc_pass` high and stores its data.
- R5: A conditional write that fails answers with `rsp_sc_pass` low and `rsp_rdata` zero, and leaves the memory unchanged.
- R6: Every conditional write drops the reservation, whether it passes or fails. A second conditional write with no new reserving read fails.
- R7: A snooped write to the reserved word drops the reservation. A snooped write to any other word has no effect on it.
- R8: A plain local write to the reserved word drops the reservation. A plain write to another word does not.
- R9: A conditional write to a word other than the reserved one fails.
- R10: A new reserving read replaces the reserved address, so the earlier word is no longer reserved.
- R11: A snooped write to the same word in the same cycle as a conditional write makes that conditional write fail. A snooped write to the same word in the same cycle as a reserving read leaves no reservation.
- R12: Address bits 1:0 are ignored for every request and for the snoop port.
- R13: `req_ready` is always high. Each accepted request produces exactly one response cycle, the next one, and there is no response without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (always high) |
| req_op | input | 2 | 00 read, 01 write, 10 reserving read, 11 conditional write |
| req_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_rdata | output | DATA_W | Read data, zero for writes |
| rsp_sc_pass | output | 1 | Conditional write committed |
| snoop_valid | input | 1 | Another agent wrote a word |
| snoop_addr | input | ADDR_W | Byte address of that write |

## Verification
A reservation flag that is stuck or wrongly cleared shows up at the next conditional write. Its pass bit is wrong one cycle after acceptance. When the write wrongly commits, a later read of the word also returns the wrong value. A stored reservation address that is wrong shows up the same way, but only when a conditional write lands on one of the two words involved. For this reason the stimulus keeps its addresses within a few words, so that reservations, snoops and stores collide often. A bad memory write shows up on the first later read of that word.

// File: rtl/lrsc_pkg.sv
`timescale 1ns/1ps
package lrsc_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_RSV   = 2'b10,
        OP_COND  = 2'b11
    } lrsc_op_e;
endpackage

// File: rtl/lrsc_wordmem.sv
`timescale 1ns/1ps
module lrsc_wordmem #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem_q[g] <= '0;
                end else begin
                    mem_q[g] <= mem_d[g];
                end
            end
        end
    endgenerate

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/lrsc_resv.sv
`timescale 1ns/1ps
module lrsc_resv #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rsv_en,
    input  logic             cond_en,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             snp_en,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             resv_valid,
    output logic [IDX_W-1:0] resv_idx,
    output logic             cond_ok
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } resv_t;

    resv_t st_q, st_d;
    logic  snp_on_req;

    always_comb begin
        snp_on_req = snp_en && (snp_idx == req_idx);
        cond_ok    = st_q.valid && (st_q.idx == req_idx) && !snp_on_req;

        st_d = st_q;
        if (snp_en && (snp_idx == st_q.idx)) begin
            st_d.valid = 1'b0;
        end
        if (wr_en && (req_idx == st_q.idx)) begin
            st_d.valid = 1'b0;
        end
        if (cond_en) begin
            st_d.valid = 1'b0;
        end
        if (rsv_en) begin
            st_d.valid = !snp_on_req;
            st_d.idx   = req_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign resv_valid = st_q.valid;
    assign resv_idx   = st_q.idx;
endmodule

// File: rtl/lrsc_monitor.sv
`timescale 1ns/1ps
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_sc_pass,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr
);
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] rdata;
        logic              pass;
    } rsp_t;

    rsp_t              rsp_q, rsp_d;
    lrsc_op_e          op;
    logic              fire;
    logic [IDX_W-1:0]  req_idx;
    logic [IDX_W-1:0]  snp_idx;
    logic [DATA_W-1:0] rd_data;
    logic              resv_valid;
    logic [IDX_W-1:0]  resv_idx;
    logic              cond_ok;
    logic              mem_we;
    logic              unused_lowbits;

    assign req_ready      = 1'b1;
    assign fire           = req_valid && req_ready;
    assign op             = lrsc_op_e'(req_op);
    assign req_idx        = req_addr[ADDR_W-1:2];
    assign snp_idx        = snoop_addr[ADDR_W-1:2];
    assign unused_lowbits = ^{req_addr[1:0], snoop_addr[1:0]};
    assign mem_we         = fire && ((op == OP_WRITE) || ((op == OP_COND) && cond_ok));

    lrsc_wordmem #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_idx),
        .rd_data (rd_data),
        .wr_en   (mem_we),
        .wr_idx  (req_idx),
        .wr_data (req_wdata)
    );

    lrsc_resv #(
        .IDX_W (IDX_W)
    ) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsv_en     (fire && (op == OP_RSV)),
        .cond_en    (fire && (op == OP_COND)),
        .wr_en      (fire && (op == OP_WRITE)),
        .req_idx    (req_idx),
        .snp_en     (snoop_valid),
        .snp_idx    (snp_idx),
        .resv_valid (resv_valid),
        .resv_idx   (resv_idx),
        .cond_ok    (cond_ok)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = fire;
        if (fire) begin
            unique case (op)
                OP_READ, OP_RSV: rsp_d.rdata = rd_data;
                OP_COND:         rsp_d.pass  = cond_ok;
                default:         rsp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_rdata   = rsp_q.rdata;
    assign rsp_sc_pass = rsp_q.pass;
endmodule

// File: rtl/lrsc_monitor_chk.sv
`timescale 1ns/1ps
module lrsc_monitor_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              snoop_valid,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              rsp_valid,
    input logic              rsp_sc_pass,
    input logic              resv_valid,
    input logic [ADDR_W-3:0] resv_idx
);
    logic take;
    logic snp_same;
    assign take     = req_valid && req_ready;
    assign snp_same = snoop_valid && (snoop_addr[ADDR_W-1:2] == req_addr[ADDR_W-1:2]);

    a_r13_rsp_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> rsp_valid);

    a_r13_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r6_cond_drops_resv: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == 2'b11) |=> !resv_valid);

    a_r4_rsv_sets_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == 2'b10 && !snp_same)
        |=> (resv_valid && resv_idx == $past(req_addr[ADDR_W-1:2])));

    a_r7_snoop_drops_resv: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_valid && snoop_valid && snoop_addr[ADDR_W-1:2] == resv_idx
         && !(take && req_op == 2'b10)) |=> !resv_valid);

    a_r5_pass_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sc_pass |-> $past(resv_valid));

    a_r9_pass_same_word: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sc_pass |-> ($past(resv_idx) == $past(req_addr[ADDR_W-1:2])));

    a_r11_snoop_beats_cond: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == 2'b11 && snp_same) |=> !rsp_sc_pass);
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .rsp_valid   (rsp_valid),
    .rsp_sc_pass (rsp_sc_pass),
    .resv_valid  (resv_valid),
    .resv_idx    (resv_idx)
);

// File: tb/lrsc_monitor_bench.sv
`timescale 1ns/1ps
module lrsc_monitor_bench;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_sc_pass;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;

    int vectors = 0;
    int miscompares = 0;

    logic [DW-1:0]   m_mem [64];
    logic            m_rv;
    logic [AW-3:0]   m_ri;

    always #4 clk = ~clk;

    lrsc_monitor #(.ADDR_W(AW), .DATA_W(DW)) u_lrsc_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_sc_pass(rsp_sc_pass),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr)
    );

    function automatic logic exp_pass(input logic [AW-3:0] idx, input logic sv, input logic [AW-3:0] sidx);
        return m_rv && (m_ri == idx) && !(sv && sidx == idx);
    endfunction

    function automatic logic [DW-1:0] exp_rdata(input logic [1:0] op, input logic [AW-3:0] idx);
        return (op == 2'b00 || op == 2'b10) ? m_mem[idx] : '0;
    endfunction

    task automatic fail_line(input string tag, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        miscompares++;
        $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    endtask

    task automatic step(input logic v, input logic [1:0] op, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wd, input logic sv, input logic [AW-1:0] sa,
                        input string tag);
        logic [AW-3:0] idx;
        logic [AW-3:0] sidx;
        logic          e_p;
        logic [DW-1:0] e_d;
        idx  = addr[AW-1:2];
        sidx = sa[AW-1:2];
        req_valid = v; req_op = op; req_addr = addr; req_wdata = wd;
        snoop_valid = sv; snoop_addr = sa;
        e_p = v && op == 2'b11 && exp_pass(idx, sv, sidx);
        e_d = v ? exp_rdata(op, idx) : '0;
        @(posedge clk);
        if (v && (op == 2'b01 || e_p)) m_mem[idx] = wd;
        if (sv && sidx == m_ri) m_rv = 1'b0;
        if (v && op == 2'b01 && idx == m_ri) m_rv = 1'b0;
        if (v && op == 2'b11) m_rv = 1'b0;
        if (v && op == 2'b10) begin
            m_rv = !(sv && sidx == idx);
            m_ri = idx;
        end
        @(negedge clk);
        req_valid = 1'b0; snoop_valid = 1'b0;
        vectors++;
        if (rsp_valid !== v) fail_line(tag, "rsp_valid", DW'(rsp_valid), DW'(v));
        else if (v && rsp_rdata !== e_d) fail_line(tag, "rsp_rdata", rsp_rdata, e_d);
        else if (v && rsp_sc_pass !== e_p) fail_line(tag, "rsp_sc_pass", DW'(rsp_sc_pass), DW'(e_p));
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        m_rv = 1'b0;
        m_ri = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        vectors++;
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1)
            fail_line("R1", "reset outputs", DW'({rsp_valid, req_ready}), DW'(2'b01));

        step(1, 2'b11, 8'h10, 32'hAAAA_AAAA, 0, 8'h00, "R1");
        step(1, 2'b00, 8'h10, 32'h0, 0, 8'h00, "R1");
        step(1, 2'b01, 8'h10, 32'h1111_1111, 0, 8'h00, "R3");
        step(1, 2'b00, 8'h10, 32'h0, 0, 8'h00, "R2");
        step(1, 2'b10, 8'h10, 32'h0, 0, 8'h00, "R2");
        step(1, 2'b11, 8'h10, 32'h2222_2222, 0, 8'h00, "R4");
        step(1, 2'b11, 8'h10, 32'h3333_3333, 0, 8'h00, "R6");
        step(1, 2'b00, 8'h10, 32'h0, 0, 8'h00, "R5");
        step(1, 2'b10, 8'h20, 32'h0, 0, 8'h00, "R2");
        step(1, 2'b11, 8'h24, 32'h4444_4444, 0, 8'h00, "R9");
        step(1, 2'b00, 8'h24, 32'h0, 0, 8'h00, "R5");
        step(1, 2'b10, 8'h20, 32'h0, 0, 8'h00, "R7");
        step(0, 2'b00, 8'h00, 32'h0, 1, 8'h30, "R7");
        step(1, 2'b11, 8'h20, 32'h5555_5555, 0, 8'h00, "R7");
        step(1, 2'b10, 8'h20, 32'h0, 0, 8'h00, "R7");
        step(0, 2'b00, 8'h00, 32'h0, 1, 8'h22, "R7");
        step(1, 2'b11, 8'h20, 32'h6666_6666, 0, 8'h00, "R7");
        step(1, 2'b10, 8'h20, 32'h0, 0, 8'h00, "R8");
        step(1, 2'b01, 8'h24, 32'h7777_7777, 0, 8'h00, "R8");
        step(1, 2'b11, 8'h20, 32'h8888_8888, 0, 8'h00, "R8");
        step(1, 2'b10, 8'h20, 32'h0, 0, 8'h00, "R8");
        step(1, 2'b01, 8'h20, 32'h9999_9999, 0, 8'h00, "R8");
        step(1, 2'b11, 8'h20, 32'hBBBB_BBBB, 0, 8'h00, "R8");
        step(1, 2'b10, 8'h20, 32'h0, 0, 8'h00, "R10");
        step(1, 2'b10, 8'h30, 32'h0, 0, 8'h00, "R10");
        step(1, 2'b11, 8'h20, 32'hCCCC_CCCC, 0, 8'h00, "R10");
        step(1, 2'b10, 8'h20, 32'h0, 0, 8'h00, "R11");
        step(1, 2'b11, 8'h20, 32'hDDDD_DDDD, 1, 8'h21, "R11");
        step(1, 2'b10, 8'h20, 32'h0, 1, 8'h23, "R11");
        step(1, 2'b11, 8'h20, 32'hEEEE_EEEE, 0, 8'h00, "R11");
        step(1, 2'b10, 8'h21, 32'h0, 0, 8'h00, "R12");
        step(1, 2'b11, 8'h23, 32'h1234_5678, 0, 8'h00, "R12");
        step(1, 2'b00, 8'h22, 32'h0, 0, 8'h00, "R12");
        step(0, 2'b10, 8'h20, 32'h0, 0, 8'h00, "R13");
        step(1, 2'b11, 8'h20, 32'h0, 0, 8'h00, "R13");

        for (int n = 0; n < 4000; n++) begin
            logic [1:0]    op;
            logic [AW-1:0] a;
            logic [AW-1:0] s;
            string         tag;
            op = 2'($urandom);
            a  = {4'b0001, 2'($urandom), 2'($urandom)};
            s  = {4'b0001, 2'($urandom), 2'($urandom)};
            case (op)
                2'b00:   tag = "R2";
                2'b01:   tag = "R3";
                2'b10:   tag = "R10";
                default: tag = "R4";
            endcase
            step(($urandom % 100) < 85, op, a, $urandom, ($urandom % 100) < 20, s, tag);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule